// File: doc/BRIEF.md
# Pattern Page Mapper with Tile-Triggered Half Selection

This block turns an address in the 8 KB pattern space of a picture processor into a physical 1 KB page number in character memory. Eight bank numbers, each 16 bits wide, are held in sixteen byte registers. One byte register holds the lower eight bits of a bank number and a second byte register holds the upper eight bits. The CPU loads these registers through a plain write strobe. A control byte sets the page granularity to 8, 4, 2 or 1 KB. An outer byte either confines every bank to one of eight 256 KB blocks or lets the full 16-bit bank number through.

In 4 KB granularity each half of the pattern space can follow a one-bit selector. The selector flips when the picture processor reads particular tile rows. This lets a tile set change part way through a frame with no CPU involvement. When selection is disabled, the lower half is fixed to bank 0 and the upper half to bank 4.

The result is registered. The page for the address presented in one cycle appears at the output after the next rising clock edge.

Top module: `chr_page_mapper`

## Requirements
- R1: A write with `cpu_wr` high and `cpu_addr[15:12]` equal to `LO_REGION` (default 0x9) loads the lower byte of bank `cpu_addr[2:0]`. A write whose `cpu_addr[15:12]` equals `HI_REGION` (default 0xA) loads the upper byte. Address bits [11:3] are ignored. Writes to any other region change no bank.
- R2: Synchronous reset sets all sixteen byte registers to 0xFF, clears both selectors and clears the output to 0.
- R3: Bank number i equals its lower byte OR (its upper byte shifted left by 8).
- R4: With `ctrl[4:3]`=00 (8 KB), the page is bank 0 times 8 plus `ppu_addr[12:10]`.
- R5: With `ctrl[4:3]`=10 (2 KB), the bank index is {`ppu_addr[12:11]`,0}. The page is that bank times 2 plus `ppu_addr[10]`.
- R6: With `ctrl[4:3]`=11 (1 KB), the bank index is `ppu_addr[12:10]` and the page equals the bank.
- R7: With `ctrl[4:3]`=01 (4 KB), the page is bank times 4 plus `ppu_addr[11:10]`. The bank index is {`ppu_addr[12`], selector[`ppu_addr[12]`] AND `latch_en`, 0}.
- R8: With `outer[5]`=0, the bank is first masked to its low G bits, where G is 5, 6, 7 or 8 for 8/4/2/1 KB. It is then ORed with {`outer[4:3]`,`outer[0]`} shifted left by G. The output page is therefore below 2048, and its bits [10:8] equal that 3-bit field.
- R9: With `outer[5]`=1, the full 16-bit bank is used with no mask and no block field.
- R10: When `latch_en` is high, a read (`ppu_rd` high) whose `ppu_addr[13]`=0, `ppu_addr[11:8]`=0xF and `ppu_addr[7:4]` in {0xD,0xE} updates the selector chosen by `ppu_addr[12]`. The selector is set to 0 for 0xD and to 1 for 0xE. No other access changes a selector.
- R11: A selector update affects the fetch after the one that triggered it, not the triggering fetch itself.
- R12: While `latch_en` is low, both selectors are cleared, and the 4 KB halves use banks 0 and 4.
- R13: `chr_page` reflects the inputs one clock edge after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ctrl | input | 8 | Control byte, bits [4:3] page granularity |
| outer | input | 8 | Outer byte: bit 5 full-bank, bits {4:3,0} block number |
| latch_en | input | 1 | Enables tile-triggered half selection |
| ppu_addr | input | 14 | Picture processor fetch address |
| ppu_rd | input | 1 | Picture processor read strobe |
| chr_page | output | 19 | Physical 1 KB page number, registered |

## Verification
The bench aims at the trigger fetch itself. It checks that this fetch still uses the old selection, so a design that bypassed the selector update combinationally would show the new bank one fetch early. It drives near-miss addresses, such as reads with the strobe low, the wrong row nibble, or `ppu_addr[13]` set. A decoder that was too loose would flip a selector on these. It also exercises the block field at each granularity, where a wrong shift or mask width would corrupt bits [10:8] or leak high bank bits into the page. Register writes go to neighbouring CPU regions with stray middle address bits. A decoder that looked at too many or too few bits would corrupt a bank.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  typedef enum logic [1:0] {
    PG_8K = 2'b00,
    PG_4K = 2'b01,
    PG_2K = 2'b10,
    PG_1K = 2'b11
  } page_size_e;

  localparam int FULL_BANK_BIT = 5;
  localparam int BASE_GRAIN    = 5;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs #(
  parameter int NUM_BANKS = 8,
  parameter int BYTE_W    = 8,
  parameter int CPU_AW    = 16,
  parameter logic [3:0] LO_REGION = 4'h9,
  parameter logic [3:0] HI_REGION = 4'hA
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [CPU_AW-1:0]                     wr_addr,
  input  logic [BYTE_W-1:0]                     wr_data,
  output logic [NUM_BANKS-1:0][2*BYTE_W-1:0]    bank_q
);
  localparam int IDX_W = $clog2(NUM_BANKS);

  logic [BYTE_W-1:0]    lo_q [NUM_BANKS];
  logic [BYTE_W-1:0]    hi_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] hit_lo;
  logic [NUM_BANKS-1:0] hit_hi;
  logic                 in_lo;
  logic                 in_hi;

  assign in_lo = wr_en && (wr_addr[CPU_AW-1:CPU_AW-4] == LO_REGION);
  assign in_hi = wr_en && (wr_addr[CPU_AW-1:CPU_AW-4] == HI_REGION);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign hit_lo[g] = in_lo && (wr_addr[IDX_W-1:0] == IDX_W'(g));
    assign hit_hi[g] = in_hi && (wr_addr[IDX_W-1:0] == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[g] <= '1;
        hi_q[g] <= '1;
      end else begin
        if (hit_lo[g]) lo_q[g] <= wr_data;
        if (hit_hi[g]) hi_q[g] <= wr_data;
      end
    end

    assign bank_q[g] = {hi_q[g], lo_q[g]};
  end

  // R1: without a write strobe no bank moves
  assert_idle_stable_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bank_q));

  // R1: writes outside both register regions are ignored
  assert_foreign_region_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[CPU_AW-1:CPU_AW-4] != LO_REGION &&
     wr_addr[CPU_AW-1:CPU_AW-4] != HI_REGION) |=> $stable(bank_q));
endmodule

// File: rtl/chr_tile_latch.sv
module chr_tile_latch #(
  parameter int PPU_AW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_en,
  input  logic              ppu_rd,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic [1:0]        sel_q
);
  logic row_d;
  logic row_e;
  logic trig;

  assign row_d = ppu_addr[7:4] == 4'hD;
  assign row_e = ppu_addr[7:4] == 4'hE;
  assign trig  = ppu_rd && !ppu_addr[13] && (ppu_addr[11:8] == 4'hF) && (row_d || row_e);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (!latch_en) begin
      sel_q <= '0;
    end else if (trig) begin
      sel_q[ppu_addr[12]] <= row_e;
    end
  end

  // R12: disabling the selection clears both selectors
  assert_disable_clears_R12: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> sel_q == 2'b00);

  // R10: selectors move only on a read strobe
  assert_no_read_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (latch_en && !ppu_rd) |=> $stable(sel_q));

  // R10: a read at or above the pattern space never moves a selector
  assert_high_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (latch_en && ppu_addr[13]) |=> $stable(sel_q));
endmodule

// File: rtl/chr_page_calc.sv
module chr_page_calc
  import chr_map_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 16,
  parameter int PAGE_W    = BANK_W + 3
) (
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] banks,
  input  logic [1:0]                       size_raw,
  input  logic [7:0]                       outer,
  input  logic [2:0]                       win,
  input  logic [1:0]                       sel,
  output logic [PAGE_W-1:0]                page
);
  localparam int IDX_W = $clog2(NUM_BANKS);

  page_size_e         size;
  logic [IDX_W-1:0]   idx;
  logic [2:0]         low;
  logic [1:0]         shamt;
  logic [3:0]         grain;
  logic [BANK_W-1:0]  raw;
  logic [BANK_W-1:0]  inner_mask;
  logic [BANK_W-1:0]  blk_field;
  logic [BANK_W-1:0]  eff;

  assign size = page_size_e'(size_raw);

  always_comb begin
    idx = '0;
    low = '0;
    unique case (size)
      PG_8K: begin idx = '0;                        low = win;                end
      PG_4K: begin idx = {win[2], sel[win[2]], 1'b0}; low = {1'b0, win[1:0]}; end
      PG_2K: begin idx = {win[2:1], 1'b0};            low = {2'b00, win[0]};  end
      PG_1K: begin idx = win;                         low = 3'b000;           end
      default: begin idx = '0; low = '0; end
    endcase
  end

  always_comb begin
    shamt      = 2'd3 - size_raw;
    grain      = 4'(BASE_GRAIN) + {2'b00, size_raw};
    raw        = banks[idx];
    inner_mask = ~({BANK_W{1'b1}} << grain);
    blk_field  = BANK_W'({outer[4:3], outer[0]}) << grain;
    eff        = outer[FULL_BANK_BIT] ? raw : ((raw & inner_mask) | blk_field);
    page       = (PAGE_W'(eff) << shamt) | PAGE_W'(low);
  end
endmodule

// File: rtl/chr_page_mapper.sv
module chr_page_mapper
  import chr_map_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BYTE_W    = 8,
  parameter int CPU_AW    = 16,
  parameter int PPU_AW    = 14,
  parameter logic [3:0] LO_REGION = 4'h9,
  parameter logic [3:0] HI_REGION = 4'hA,
  parameter int BANK_W    = 2 * BYTE_W,
  parameter int PAGE_W    = BANK_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  input  logic [7:0]        ctrl,
  input  logic [7:0]        outer,
  input  logic              latch_en,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              ppu_rd,
  output logic [PAGE_W-1:0] chr_page
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
  logic [1:0]                       sel_q;
  logic [1:0]                       sel_eff;
  logic [PAGE_W-1:0]                page_d;

  chr_bank_regs #(
    .NUM_BANKS (NUM_BANKS),
    .BYTE_W    (BYTE_W),
    .CPU_AW    (CPU_AW),
    .LO_REGION (LO_REGION),
    .HI_REGION (HI_REGION)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_wr),
    .wr_addr (cpu_addr),
    .wr_data (cpu_wdata),
    .bank_q  (banks)
  );

  chr_tile_latch #(
    .PPU_AW (PPU_AW)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .latch_en (latch_en),
    .ppu_rd   (ppu_rd),
    .ppu_addr (ppu_addr),
    .sel_q    (sel_q)
  );

  assign sel_eff = latch_en ? sel_q : 2'b00;

  chr_page_calc #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .PAGE_W    (PAGE_W)
  ) u_calc (
    .banks    (banks),
    .size_raw (ctrl[4:3]),
    .outer    (outer),
    .win      (ppu_addr[12:10]),
    .sel      (sel_eff),
    .page     (page_d)
  );

  always_ff @(posedge clk) begin
    if (rst) chr_page <= '0;
    else     chr_page <= page_d;
  end

  // R8: a confined bank always lands inside its 256 KB block
  assert_block_confined_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(outer[FULL_BANK_BIT])) |->
      (chr_page[PAGE_W-1:11] == '0 &&
       chr_page[10:8] == {$past(outer[4:3]), $past(outer[0])}));

  // R13: output is frozen when nothing feeding it changed
  assert_registered_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !cpu_wr && !$past(cpu_wr) && !ppu_rd && !$past(ppu_rd) &&
     $stable(ppu_addr) && $stable(ctrl) && $stable(outer) && $stable(latch_en))
      |=> $stable(chr_page));
endmodule

// File: tb/chr_page_mapper_bench.sv
module chr_page_mapper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  ctrl = '0;
  logic [7:0]  outer = '0;
  logic        latch_en = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0;
  logic [18:0] chr_page;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [7:0] m_lo [8];
  logic [7:0] m_hi [8];
  logic [1:0] m_sel;

  always #10 clk = ~clk;

  chr_page_mapper u_chr_page_mapper (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ctrl(ctrl), .outer(outer), .latch_en(latch_en),
    .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .chr_page(chr_page)
  );

  function automatic logic [18:0] exp_page(logic [13:0] a, logic [7:0] c, logic [7:0] o,
                                            logic le, logic [1:0] s);
    logic [2:0]  idx;
    logic [2:0]  low;
    int          g;
    int          sh;
    logic [15:0] raw;
    logic [15:0] eff;
    case (c[4:3])
      2'd0: begin idx = 3'd0; low = a[12:10]; end
      2'd1: begin idx = {a[12], s[a[12]] & le, 1'b0}; low = {1'b0, a[11:10]}; end
      2'd2: begin idx = {a[12:11], 1'b0}; low = {2'b0, a[10]}; end
      default: begin idx = a[12:10]; low = 3'd0; end
    endcase
    g   = 5 + int'(c[4:3]);
    sh  = 3 - int'(c[4:3]);
    raw = {m_hi[idx], m_lo[idx]};
    if (o[5]) eff = raw;
    else eff = (raw & 16'((32'd1 << g) - 1)) | 16'(32'({o[4:3], o[0]}) << g);
    return (19'(eff) << sh) | 19'(low);
  endfunction

  function automatic string mode_tag(logic [7:0] c, logic [7:0] o);
    string t;
    case (c[4:3])
      2'd0: t = "R4";
      2'd1: t = "R7";
      2'd2: t = "R5";
      default: t = "R6";
    endcase
    return $sformatf("%s/%s/R3/R13", t, o[5] ? "R9" : "R8");
  endfunction

  task automatic chk(logic [18:0] act, logic [18:0] expv, string tag);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // one clock: model the edge, then compare at the following falling edge
  task automatic tick(string tag);
    logic [18:0] e;
    e = exp_page(ppu_addr, ctrl, outer, latch_en, m_sel);
    if (cpu_wr && cpu_addr[15:12] == 4'h9) m_lo[cpu_addr[2:0]] = cpu_wdata;
    if (cpu_wr && cpu_addr[15:12] == 4'hA) m_hi[cpu_addr[2:0]] = cpu_wdata;
    if (!latch_en) m_sel = 2'b00;
    else if (ppu_rd && !ppu_addr[13] && ppu_addr[11:8] == 4'hF &&
             (ppu_addr[7:4] == 4'hD || ppu_addr[7:4] == 4'hE))
      m_sel[ppu_addr[12]] = (ppu_addr[7:4] == 4'hE);
    @(negedge clk);
    chk(chr_page, e, (tag == "") ? mode_tag(ctrl, outer) : tag);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick(tag);
    cpu_wr = 1'b0;
  endtask

  task automatic fetch(logic [13:0] a, logic rd, string tag);
    ppu_addr = a; ppu_rd = rd;
    tick(tag);
    ppu_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int r;
    r = int'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin m_lo[i] = 8'hFF; m_hi[i] = 8'hFF; end
    m_sel = 2'b00;

    // R2: reset state
    @(negedge clk); @(negedge clk);
    chk(chr_page, 19'h0, "R2 reset output");
    rst = 1'b0;

    // R2: registers come up as 0xFF, 8 KB confined to block 0
    fetch(14'h0400, 1'b0, "R2 power-up bank");
    chk(chr_page, 19'h000F9, "R2 power-up value");

    // R3, R6, R9: full 16-bit bank in 1 KB mode
    ctrl = 8'h18; outer = 8'h20;
    wr(16'h9003, 8'h34, "R1 low write");
    wr(16'hA003, 8'h12, "R1 high write");
    fetch(14'h0C00, 1'b0, "R3 bank assembly");
    chk(chr_page, 19'h01234, "R3 exact bank");
    // R1: foreign region and stray middle bits
    wr(16'hB003, 8'h00, "R1 foreign region");
    wr(16'h8003, 8'h00, "R1 foreign region");
    fetch(14'h0C00, 1'b0, "R1 foreign ignored");
    chk(chr_page, 19'h01234, "R1 foreign ignored");
    wr(16'h9FF3, 8'h56, "R1 stray bits");
    fetch(14'h0C00, 1'b0, "R1 stray bits");
    chk(chr_page, 19'h01256, "R1 stray bits decode");

    // R7, R10, R11: 4 KB with selectors
    ctrl = 8'h08; latch_en = 1'b1;
    wr(16'h9000, 8'h10, ""); wr(16'hA000, 8'h00, "");
    wr(16'h9002, 8'h22, ""); wr(16'hA002, 8'h00, "");
    wr(16'h9004, 8'h44, ""); wr(16'hA004, 8'h00, "");
    wr(16'h9006, 8'h66, ""); wr(16'hA006, 8'h00, "");
    fetch(14'h0FE0, 1'b1, "R11 trigger uses old");
    chk(chr_page, 19'h00043, "R11 trigger fetch");
    fetch(14'h0000, 1'b0, "R10 lower now bank 2");
    chk(chr_page, 19'h00088, "R10 lower selector");
    fetch(14'h1FE5, 1'b0, "R10 no strobe");
    chk(chr_page, 19'h00113, "R10 strobe low ignored");
    fetch(14'h1000, 1'b0, "R10 upper unchanged");
    chk(chr_page, 19'h00110, "R10 upper still bank 4");
    fetch(14'h1FE0, 1'b1, "R11 upper trigger");
    fetch(14'h1000, 1'b0, "R10 upper bank 6");
    chk(chr_page, 19'h00198, "R10 upper selector");
    fetch(14'h0FD0, 1'b1, "R10 back to bank 0");
    fetch(14'h0000, 1'b0, "R10 lower bank 0");
    chk(chr_page, 19'h00040, "R10 row D clears");
    // R12: disable forces 0/4
    latch_en = 1'b0;
    fetch(14'h1000, 1'b0, "R12 fixed upper");
    chk(chr_page, 19'h00110, "R12 fixed bank 4");
    latch_en = 1'b1;
    fetch(14'h1000, 1'b0, "R12 cleared on disable");
    chk(chr_page, 19'h00110, "R12 selector cleared");

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      int k;
      k = int'($urandom % 8);
      if ($urandom % 3 == 0)
        ppu_addr = {1'b0, 1'($urandom), 4'hF, (($urandom % 2) ? 4'hD : 4'hE), 4'($urandom)};
      else
        ppu_addr = 14'($urandom);
      ppu_rd = 1'($urandom);
      if (k < 2) begin
        cpu_wr = 1'b1;
        cpu_addr = {4'h8 + 4'($urandom % 4), 12'($urandom)};
        cpu_wdata = 8'($urandom);
      end else if (k == 2) begin
        ctrl = 8'($urandom);
        outer = 8'($urandom);
        latch_en = ($urandom % 4) != 0;
      end
      tick("");
      cpu_wr = 1'b0;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule